// File: doc/BRIEF.md
# Vector-length CSR read rewriter

This decode-stage unit removes the need for CSR-specific interlocks around reads of the vector length. It keeps a small alias register that holds the index of the scalar register that currently stands in for the vector length. When an instruction arrives that reads the vector-length CSR, and the alias register is non-zero, the unit replaces that instruction with a plain register move. The move copies from the aliased scalar register into the original destination. Downstream, the move then takes part in ordinary scalar dependency tracking.

An alias value of zero means that no scalar register stands in for the vector length. In that case every instruction leaves the unit unchanged. The alias register is loaded through a write-enable port. The output is a registered instruction word with one cycle of latency, and its valid strobe travels with the word.

Top module: `vl_csr_rewriter`

## Requirements
- R1: During reset and on the first output after reset, `out_valid` is 0 and the alias register holds 0. As a result, a vector-length CSR read sent right after reset leaves the unit unchanged.
- R2: `out_valid` in cycle t+1 equals `in_valid` in cycle t. The unit has exactly one register stage, and words are accepted back to back.
- R3: While the alias register holds 0, `out_instr` in cycle t+1 equals `in_instr` in cycle t for every instruction word.
- R4: A vector-length CSR read is recognised only when all four of these hold: bits 6:0 = 1110011, bits 14:12 = 010, bits 19:15 = 00000, and bits 31:20 equal the parameter `VL_CSR_ADDR` (default 0xC20).
- R5: A recognised read seen while the alias register holds a non-zero value N leaves the unit as a move of the form ADDI rd, xN, 0. In that word, bits 31:20 are 0, bits 19:15 are N, bits 14:12 are 000, bits 11:7 keep the original rd, and bits 6:0 are 0010011.
- R6: Some words come close to a read without being one: a different CSR address, a non-zero bits 19:15, a different bits 14:12 (for example 001), or an ordinary non-CSR instruction. All of these pass through unchanged even when the alias register is non-zero.
- R7: When `alias_we` is high at a clock edge, the alias register takes `alias_idx`. An instruction presented in that same cycle is judged against the old alias value, and the new value applies from the next instruction onwards.
- R8: Writing 0 to the alias register turns rewriting off, and later reads pass through unchanged. Writing a different non-zero index redirects later moves to that index.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Incoming instruction is valid |
| in_instr | input | 32 | Incoming instruction word |
| alias_we | input | 1 | Load enable for the alias register |
| alias_idx | input | 5 | Scalar register index to alias to the vector length |
| out_valid | output | 1 | Outgoing instruction is valid |
| out_instr | output | 32 | Outgoing, possibly rewritten, instruction word |

## Verification
The hardest case to reach from the ports is a read that arrives in the same cycle as an alias write. The read has to be judged against the old alias value, so it cannot be told apart from a correct design unless the old and new values lead to different outputs. The stimulus therefore writes to the alias register while a vector-length read is in flight, in two situations: a switch from zero to non-zero, and a switch from one non-zero index to another. It then sends a second read to show that the new index has taken effect. Words that differ from a real read in only one field are sent while the alias register is non-zero, so that each recognition condition is exercised on its own.

// File: rtl/vlmv_pkg.sv
package vlmv_pkg;

    localparam int INSTR_W = 32;
    localparam int REG_IDX_W = 5;
    localparam int CSR_ADDR_W = 12;

    localparam logic [6:0] OPC_SYSTEM = 7'b1110011;
    localparam logic [6:0] OPC_OPIMM = 7'b0010011;
    localparam logic [2:0] F3_CSR_SET = 3'b010;
    localparam logic [2:0] F3_ADD_IMM = 3'b000;

    // I-type layout shared by CSR reads and ADDI
    typedef struct packed {
        logic [CSR_ADDR_W-1:0] imm;
        logic [REG_IDX_W-1:0] src;
        logic [2:0] f3;
        logic [REG_IDX_W-1:0] dst;
        logic [6:0] opc;
    } itype_word_t;

    typedef struct packed {
        logic valid;
        itype_word_t word;
    } slot_t;

    function automatic logic is_len_read(input itype_word_t w,
                                         input logic [CSR_ADDR_W-1:0] addr);
        return (w.opc == OPC_SYSTEM) && (w.f3 == F3_CSR_SET) &&
               (w.src == '0) && (w.imm == addr);
    endfunction

    function automatic itype_word_t make_move(input logic [REG_IDX_W-1:0] dst,
                                              input logic [REG_IDX_W-1:0] src);
        itype_word_t m;
        m.imm = '0;
        m.src = src;
        m.f3 = F3_ADD_IMM;
        m.dst = dst;
        m.opc = OPC_OPIMM;
        return m;
    endfunction

endpackage

// File: rtl/vl_alias_reg.sv
module vl_alias_reg
    import vlmv_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 we,
    input  logic [REG_IDX_W-1:0] wr_idx,
    output logic [REG_IDX_W-1:0] idx_q,
    output logic                 alias_on
);
    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q <= '0;
        end else if (we) begin
            idx_q <= wr_idx;
        end
    end

    assign alias_on = (idx_q != '0);
endmodule

// File: rtl/vl_read_detect.sv
module vl_read_detect
    import vlmv_pkg::*;
#(
    parameter logic [CSR_ADDR_W-1:0] VL_CSR_ADDR = 12'hC20
) (
    input  itype_word_t word,
    output logic        hit
);
    assign hit = is_len_read(word, VL_CSR_ADDR);
endmodule

// File: rtl/vl_out_stage.sv
module vl_out_stage
    import vlmv_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  slot_t d,
    output slot_t q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q.valid <= 1'b0;
            q.word <= '0;
        end else begin
            q <= d;
        end
    end
endmodule

// File: rtl/vl_csr_rewriter.sv
module vl_csr_rewriter
    import vlmv_pkg::*;
#(
    parameter logic [CSR_ADDR_W-1:0] VL_CSR_ADDR = 12'hC20
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    input  logic [INSTR_W-1:0]   in_instr,
    input  logic                 alias_we,
    input  logic [REG_IDX_W-1:0] alias_idx,
    output logic                 out_valid,
    output logic [INSTR_W-1:0]   out_instr
);
    logic [REG_IDX_W-1:0] alias_q;
    logic                 alias_on;
    logic                 read_hit;
    itype_word_t          in_word;
    slot_t                nxt;
    slot_t                cur;

    assign in_word = itype_word_t'(in_instr);

    vl_alias_reg u_alias (
        .clk      (clk),
        .rst      (rst),
        .we       (alias_we),
        .wr_idx   (alias_idx),
        .idx_q    (alias_q),
        .alias_on (alias_on)
    );

    vl_read_detect #(.VL_CSR_ADDR(VL_CSR_ADDR)) u_detect (
        .word (in_word),
        .hit  (read_hit)
    );

    // The alias value used here is the registered one, so a same-cycle write
    // only affects later instructions.
    always_comb begin
        nxt.valid = in_valid;
        if (alias_on && read_hit) begin
            nxt.word = make_move(in_word.dst, alias_q);
        end else begin
            nxt.word = in_word;
        end
    end

    vl_out_stage u_out (
        .clk (clk),
        .rst (rst),
        .d   (nxt),
        .q   (cur)
    );

    assign out_valid = cur.valid;
    assign out_instr = cur.word;
endmodule

// File: rtl/vl_csr_rewriter_chk.sv
module vl_csr_rewriter_chk
    import vlmv_pkg::*;
#(
    parameter logic [CSR_ADDR_W-1:0] VL_CSR_ADDR = 12'hC20
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 in_valid,
    input logic [INSTR_W-1:0]   in_instr,
    input logic                 alias_we,
    input logic [REG_IDX_W-1:0] alias_idx,
    input logic [REG_IDX_W-1:0] alias_q,
    input logic                 out_valid,
    input logic [INSTR_W-1:0]   out_instr
);
    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (!out_valid && alias_q == '0));

    // R2
    valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid == $past(in_valid));

    // R3
    no_alias_pass_chk: assert property (@(posedge clk) disable iff (rst)
        (alias_q == '0) |=> (out_instr == $past(in_instr)));

    // R5
    move_form_chk: assert property (@(posedge clk) disable iff (rst)
        ((alias_q != '0) && is_len_read(itype_word_t'(in_instr), VL_CSR_ADDR))
        |=> (out_instr == {12'h000, $past(alias_q), 3'b000,
                           $past(in_instr[11:7]), 7'b0010011}));

    // R6
    non_read_pass_chk: assert property (@(posedge clk) disable iff (rst)
        !is_len_read(itype_word_t'(in_instr), VL_CSR_ADDR)
        |=> (out_instr == $past(in_instr)));

    // R7
    alias_load_chk: assert property (@(posedge clk) disable iff (rst)
        alias_we |=> (alias_q == $past(alias_idx)));

    // R7
    alias_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !alias_we |=> $stable(alias_q));
endmodule

bind vl_csr_rewriter vl_csr_rewriter_chk #(.VL_CSR_ADDR(VL_CSR_ADDR)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_instr  (in_instr),
    .alias_we  (alias_we),
    .alias_idx (alias_idx),
    .alias_q   (alias_q),
    .out_valid (out_valid),
    .out_instr (out_instr)
);

// File: tb/vl_csr_rewriter_tb.sv
module vl_csr_rewriter_tb;
    localparam time CLK_PERIOD = 10ns;
    localparam logic [11:0] LEN_CSR = 12'hC20;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [31:0] in_instr = '0;
    logic        alias_we = 1'b0;
    logic [4:0]  alias_idx = '0;
    logic        out_valid;
    logic [31:0] out_instr;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    vl_csr_rewriter u_dut (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_instr  (in_instr),
        .alias_we  (alias_we),
        .alias_idx (alias_idx),
        .out_valid (out_valid),
        .out_instr (out_instr)
    );

    function automatic logic [31:0] csr_word(input logic [11:0] csr, input logic [4:0] rs,
                                             input logic [2:0] f3, input logic [4:0] rd);
        return {csr, rs, f3, rd, 7'b1110011};
    endfunction

    function automatic logic [31:0] mv_word(input logic [4:0] rd, input logic [4:0] rs);
        return {12'h000, rs, 3'b000, rd, 7'b0010011};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // drive one cycle at negedge, sample after the following rising edge
    task automatic step(input logic v, input logic [31:0] w, input logic we,
                        input logic [4:0] idx);
        @(negedge clk);
        in_valid = v;
        in_instr = w;
        alias_we = we;
        alias_idx = idx;
        @(posedge clk);
        #1;
    endtask

    task automatic set_alias(input logic [4:0] idx);
        step(1'b0, 32'h0000_0013, 1'b1, idx);
    endtask

    task automatic t_reset();
        check("R1 valid in reset", {31'd0, out_valid}, 32'd0);
        @(negedge clk);
        rst = 1'b0;
        step(1'b1, csr_word(LEN_CSR, 5'd0, 3'b010, 5'd7), 1'b0, 5'd0);
        check("R1 valid", {31'd0, out_valid}, 32'd1);
        check("R1 alias zero after reset", out_instr, csr_word(LEN_CSR, 5'd0, 3'b010, 5'd7));
    endtask

    task automatic t_passthrough_zero();
        logic [31:0] w1 = 32'h00B5_0533;
        step(1'b1, w1, 1'b0, 5'd0);
        check("R3 plain word", out_instr, w1);
        step(1'b0, csr_word(LEN_CSR, 5'd0, 3'b010, 5'd9), 1'b0, 5'd0);
        check("R2 invalid propagates", {31'd0, out_valid}, 32'd0);
        check("R3 read unchanged", out_instr, csr_word(LEN_CSR, 5'd0, 3'b010, 5'd9));
    endtask

    task automatic t_rewrite();
        set_alias(5'd12);
        step(1'b1, csr_word(LEN_CSR, 5'd0, 3'b010, 5'd3), 1'b0, 5'd0);
        check("R5 move x3<-x12", out_instr, mv_word(5'd3, 5'd12));
        check("R2 valid with move", {31'd0, out_valid}, 32'd1);
        step(1'b1, csr_word(LEN_CSR, 5'd0, 3'b010, 5'd31), 1'b0, 5'd0);
        check("R5 move x31<-x12", out_instr, mv_word(5'd31, 5'd12));
        step(1'b1, csr_word(LEN_CSR, 5'd0, 3'b010, 5'd0), 1'b0, 5'd0);
        check("R5 move rd x0", out_instr, mv_word(5'd0, 5'd12));
    endtask

    task automatic t_near_miss();
        logic [31:0] w;
        w = csr_word(12'hC21, 5'd0, 3'b010, 5'd4);
        step(1'b1, w, 1'b0, 5'd0);
        check("R4 other address", out_instr, w);
        w = csr_word(LEN_CSR, 5'd6, 3'b010, 5'd4);
        step(1'b1, w, 1'b0, 5'd0);
        check("R4 rs1 nonzero", out_instr, w);
        w = csr_word(LEN_CSR, 5'd0, 3'b001, 5'd4);
        step(1'b1, w, 1'b0, 5'd0);
        check("R4 funct3 001", out_instr, w);
        w = {LEN_CSR, 5'd0, 3'b010, 5'd4, 7'b0000011};
        step(1'b1, w, 1'b0, 5'd0);
        check("R6 load opcode", out_instr, w);
        w = 32'h0010_0093;
        step(1'b1, w, 1'b0, 5'd0);
        check("R6 ordinary addi", out_instr, w);
    endtask

    task automatic t_same_cycle();
        set_alias(5'd0);
        step(1'b1, csr_word(LEN_CSR, 5'd0, 3'b010, 5'd5), 1'b1, 5'd20);
        check("R7 old zero alias used", out_instr, csr_word(LEN_CSR, 5'd0, 3'b010, 5'd5));
        step(1'b1, csr_word(LEN_CSR, 5'd0, 3'b010, 5'd5), 1'b1, 5'd21);
        check("R7 old alias 20 used", out_instr, mv_word(5'd5, 5'd20));
        step(1'b1, csr_word(LEN_CSR, 5'd0, 3'b010, 5'd6), 1'b0, 5'd0);
        check("R7 new alias 21 used", out_instr, mv_word(5'd6, 5'd21));
    endtask

    task automatic t_retarget();
        set_alias(5'd0);
        step(1'b1, csr_word(LEN_CSR, 5'd0, 3'b010, 5'd8), 1'b0, 5'd0);
        check("R8 zero disables", out_instr, csr_word(LEN_CSR, 5'd0, 3'b010, 5'd8));
        set_alias(5'd1);
        step(1'b1, csr_word(LEN_CSR, 5'd0, 3'b010, 5'd8), 1'b0, 5'd0);
        check("R8 index 1", out_instr, mv_word(5'd8, 5'd1));
        // back-to-back stream keeps order
        step(1'b1, 32'h1234_5033, 1'b0, 5'd0);
        check("R2 stream 1", out_instr, 32'h1234_5033);
        step(1'b1, csr_word(LEN_CSR, 5'd0, 3'b010, 5'd2), 1'b0, 5'd0);
        check("R2 stream 2", out_instr, mv_word(5'd2, 5'd1));
        step(1'b0, 32'h0, 1'b0, 5'd0);
        check("R2 stream end", {31'd0, out_valid}, 32'd0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        t_reset();
        t_passthrough_zero();
        t_rewrite();
        t_near_miss();
        t_same_cycle();
        t_retarget();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule